// File: doc/BRIEF.md
# Program Counter Stack with Paged Calls

This block produces the fetch address for a small processor whose return stack is no separate memory. It holds a handful of full-width program counters, and a pointer picks which one is live. A subroutine call advances the pointer to a fresh slot and loads the target there. The previous slot keeps the address just after the call and serves as the return address. A return moves the pointer back, so the return address becomes the live counter again. No data is copied on a call or a return.

The address splits into a bank field (bits 12:10), a page field (bits 9:6, pages of 64 words) and an offset (bits 5:0). Jumps and calls carry only a 6-bit offset. A jump stays in the current bank and page. A call goes by default to a fixed subroutine page (page 15) in the current bank. A page-prefix operation can be issued ahead of a jump or call. Its page then replaces the implied page for that one transfer. The instruction decoder drives one 3-bit operation code per cycle, together with the offset and the page value.

Top module: `pc_stack`

## Requirements
- R1: While `rstN` is low, all counter slots clear to 0, the pointer selects slot 0 and no page prefix is pending. After reset, `fetchAddr` is 0.
- R2: Operation code 1 (step) advances the live counter by one. The address wraps from 8191 to 0.
- R3: Operation code 0 (hold) leaves the fetch address unchanged.
- R4: Operation code 4 (jump) with no prefix pending keeps bits 12:6 of the live address and puts `targetIn` in bits 5:0.
- R5: Operation code 5 (call) with no prefix pending advances the pointer. The new live address is {current bank, page 15, `targetIn`}, and the bank is taken from bits 12:10 of the calling address.
- R6: A call leaves the calling address plus one in the slot it leaves behind. Operation code 6 (return) moves the pointer back, and the fetch address then equals that saved value.
- R7: Operation code 7 (return-and-skip) moves the pointer back and adds one to the restored slot. The fetch address becomes the calling address plus two.
- R8: Operation code 3 (prefix) advances the live counter by one and records `pageIn` as pending. The next jump or call uses that page in bits 9:6 instead of the implied page.
- R9: A pending prefix survives step, hold and skip operations. The first jump or call clears it, and later transfers use the implied page again.
- R10: Operation code 2 (skip) advances the live counter by two.
- R11: The pointer wraps modulo the slot count. With four slots, a fourth nested call overwrites the base slot with its target. Four returns then leave the fetch address equal to that target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opIn | input | 3 | Operation code: 0 hold, 1 step, 2 skip, 3 prefix, 4 jump, 5 call, 6 return, 7 return-and-skip |
| targetIn | input | 6 | Offset for jump and call |
| pageIn | input | 4 | Page value recorded by the prefix operation |
| fetchAddr | output | 13 | Live program counter, used as the fetch address |

## Verification
The bench builds the block with its default parameters: a 13-bit address, 6-bit offsets, 4-bit pages, four slots and subroutine page 15. Four slots keep pointer wrap within a few calls, so slot overwrite and return order can be observed directly. The 13-bit address can be walked to its top in about 8K steps. That brings the bank-7 call and the wrap of a return address from 8191 to 0 within the run.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    OP_HOLD    = 3'd0,
    OP_STEP    = 3'd1,
    OP_SKIP    = 3'd2,
    OP_PREFIX  = 3'd3,
    OP_JUMP    = 3'd4,
    OP_CALL    = 3'd5,
    OP_RET     = 3'd6,
    OP_RETSKIP = 3'd7
  } pcs_op_e;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic stepOne;      // live slot += 1
    logic stepTwo;      // live slot += 2
    logic loadLocal;    // live slot <= in-page jump target
    logic loadCall;     // live slot <= +1, next slot <= call target
    logic popSkip;      // slot below pointer += 1
    logic latchPage;    // record pending page prefix
    logic consumePage;  // drop pending page prefix
  } pcs_strobe_t;

endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  pcs_op_e          opCode,
  output pcs_strobe_t      strb,
  output logic [PTR_W-1:0] ptrNow,
  output logic [PTR_W-1:0] ptrUp,
  output logic [PTR_W-1:0] ptrDown
);

  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(SLOTS - 1);

  logic ptrPush;
  logic ptrPop;

  // Neighbour slots with wrap, valid for any slot count.
  always_comb begin
    ptrUp   = (ptrNow == PTR_TOP) ? '0 : ptrNow + 1'b1;
    ptrDown = (ptrNow == '0) ? PTR_TOP : ptrNow - 1'b1;
  end

  always_comb begin
    strb    = '0;
    ptrPush = 1'b0;
    ptrPop  = 1'b0;
    unique case (opCode)
      OP_HOLD: ;
      OP_STEP: strb.stepOne = 1'b1;
      OP_SKIP: strb.stepTwo = 1'b1;
      OP_PREFIX: begin
        strb.stepOne   = 1'b1;
        strb.latchPage = 1'b1;
      end
      OP_JUMP: begin
        strb.loadLocal   = 1'b1;
        strb.consumePage = 1'b1;
      end
      OP_CALL: begin
        strb.loadCall    = 1'b1;
        strb.consumePage = 1'b1;
        ptrPush          = 1'b1;
      end
      OP_RET: ptrPop = 1'b1;
      OP_RETSKIP: begin
        strb.popSkip = 1'b1;
        ptrPop       = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)        ptrNow <= '0;
    else if (ptrPush) ptrNow <= ptrUp;
    else if (ptrPop)  ptrNow <= ptrDown;
  end

endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int OFFS_W   = 6,
  parameter int PAGE_W   = 4,
  parameter int SLOTS    = 4,
  parameter int SUB_PAGE = 15,
  localparam int PTR_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int BANK_W = ADDR_W - PAGE_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcs_strobe_t       strb,
  input  logic [PTR_W-1:0]  ptrNow,
  input  logic [PTR_W-1:0]  ptrUp,
  input  logic [PTR_W-1:0]  ptrDown,
  input  logic [OFFS_W-1:0] targetIn,
  input  logic [PAGE_W-1:0] pageIn,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              prefixValid
);

  localparam logic [PAGE_W-1:0] SUB_PG = PAGE_W'(SUB_PAGE);

  logic [ADDR_W-1:0] slotQ [SLOTS];
  logic [PAGE_W-1:0] prefixPage;

  logic [BANK_W-1:0] curBank;
  logic [PAGE_W-1:0] curPage;
  logic [PAGE_W-1:0] jumpPage;
  logic [PAGE_W-1:0] callPage;
  logic [ADDR_W-1:0] jumpAddr;
  logic [ADDR_W-1:0] callAddr;
  logic [ADDR_W-1:0] seqOne;
  logic [ADDR_W-1:0] seqTwo;

  assign fetchAddr = slotQ[ptrNow];

  // Transfer targets built from the live address and the pending prefix.
  always_comb begin
    curBank  = fetchAddr[ADDR_W-1 -: BANK_W];
    curPage  = fetchAddr[OFFS_W +: PAGE_W];
    jumpPage = prefixValid ? prefixPage : curPage;
    callPage = prefixValid ? prefixPage : SUB_PG;
    jumpAddr = {curBank, jumpPage, targetIn};
    callAddr = {curBank, callPage, targetIn};
    seqOne   = fetchAddr + ADDR_W'(1);
    seqTwo   = fetchAddr + ADDR_W'(2);
  end

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    localparam logic [PTR_W-1:0] IDX = PTR_W'(g);
    logic [ADDR_W-1:0] slotD;

    always_comb begin
      slotD = slotQ[g];
      if (IDX == ptrNow) begin
        if (strb.stepOne)        slotD = seqOne;
        else if (strb.stepTwo)   slotD = seqTwo;
        else if (strb.loadLocal) slotD = jumpAddr;
        else if (strb.loadCall)  slotD = seqOne;
      end
      if (strb.loadCall && IDX == ptrUp)   slotD = callAddr;
      if (strb.popSkip && IDX == ptrDown)  slotD = slotQ[g] + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
      if (!rstN) slotQ[g] <= '0;
      else       slotQ[g] <= slotD;
    end
  end

  // Pending page prefix: a new prefix wins over a consume in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prefixValid <= 1'b0;
      prefixPage  <= '0;
    end else if (strb.latchPage) begin
      prefixValid <= 1'b1;
      prefixPage  <= pageIn;
    end else if (strb.consumePage) begin
      prefixValid <= 1'b0;
    end
  end

endmodule

// File: rtl/pc_stack.sv
module pc_stack
  import pcs_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int OFFS_W   = 6,
  parameter int PAGE_W   = 4,
  parameter int SLOTS    = 4,
  parameter int SUB_PAGE = 15,
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opIn,
  input  logic [OFFS_W-1:0] targetIn,
  input  logic [PAGE_W-1:0] pageIn,
  output logic [ADDR_W-1:0] fetchAddr
);

  pcs_strobe_t      strb;
  logic [PTR_W-1:0] ptrNow;
  logic [PTR_W-1:0] ptrUp;
  logic [PTR_W-1:0] ptrDown;
  logic             prefixValid;
  pcs_op_e          opCode;

  assign opCode = pcs_op_e'(opIn);

  pcs_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opCode  (opCode),
    .strb    (strb),
    .ptrNow  (ptrNow),
    .ptrUp   (ptrUp),
    .ptrDown (ptrDown)
  );

  pcs_datapath #(
    .ADDR_W  (ADDR_W),
    .OFFS_W  (OFFS_W),
    .PAGE_W  (PAGE_W),
    .SLOTS   (SLOTS),
    .SUB_PAGE(SUB_PAGE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .ptrNow     (ptrNow),
    .ptrUp      (ptrUp),
    .ptrDown    (ptrDown),
    .targetIn   (targetIn),
    .pageIn     (pageIn),
    .fetchAddr  (fetchAddr),
    .prefixValid(prefixValid)
  );

endmodule

// File: rtl/pc_stack_chk.sv
module pc_stack_chk #(
  parameter int ADDR_W   = 13,
  parameter int OFFS_W   = 6,
  parameter int PAGE_W   = 4,
  parameter int SLOTS    = 4,
  parameter int SUB_PAGE = 15,
  localparam int PTR_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int BANK_W = ADDR_W - PAGE_W - OFFS_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        opIn,
  input logic [OFFS_W-1:0] targetIn,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [PTR_W-1:0]  ptrNow,
  input logic              prefixValid
);

  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(SLOTS - 1);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    opIn == 3'd1 |=> fetchAddr == ADDR_W'($past(fetchAddr) + ADDR_W'(1)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    opIn == 3'd0 |=> $stable(fetchAddr));

  assert_skip_R10: assert property (@(posedge clk) disable iff (!rstN)
    opIn == 3'd2 |=> fetchAddr == ADDR_W'($past(fetchAddr) + ADDR_W'(2)));

  assert_jump_page_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opIn == 3'd4 && !prefixValid) |=>
      (fetchAddr[ADDR_W-1:OFFS_W] == $past(fetchAddr[ADDR_W-1:OFFS_W]))
      && (fetchAddr[OFFS_W-1:0] == $past(targetIn)));

  assert_call_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opIn == 3'd5 && !prefixValid) |=>
      fetchAddr == {$past(fetchAddr[ADDR_W-1 -: BANK_W]), PAGE_W'(SUB_PAGE),
                    $past(targetIn)});

  assert_call_push_R5: assert property (@(posedge clk) disable iff (!rstN)
    opIn == 3'd5 |=> ptrNow == (($past(ptrNow) == PTR_TOP) ? '0
                                : PTR_W'($past(ptrNow) + 1'b1)));

  assert_ret_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    opIn[2:1] == 2'b11 |=> ptrNow == (($past(ptrNow) == '0) ? PTR_TOP
                                      : PTR_W'($past(ptrNow) - 1'b1)));

  assert_prefix_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    opIn == 3'd3 |=> prefixValid);

  assert_prefix_used_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opIn == 3'd4 || opIn == 3'd5) |=> !prefixValid);

  assert_prefix_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (prefixValid && opIn <= 3'd2) |=> prefixValid);

endmodule

bind pc_stack pc_stack_chk #(
  .ADDR_W  (ADDR_W),
  .OFFS_W  (OFFS_W),
  .PAGE_W  (PAGE_W),
  .SLOTS   (SLOTS),
  .SUB_PAGE(SUB_PAGE)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .opIn       (opIn),
  .targetIn   (targetIn),
  .fetchAddr  (fetchAddr),
  .ptrNow     (ptrNow),
  .prefixValid(prefixValid)
);

// File: tb/sim_pc_stack.sv
module sim_pc_stack;

  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] OP_HOLD = 3'd0, OP_STEP = 3'd1, OP_SKIP = 3'd2,
                         OP_PREF = 3'd3, OP_JUMP = 3'd4, OP_CALL = 3'd5,
                         OP_RET  = 3'd6, OP_RSKP = 3'd7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opIn = OP_HOLD;
  logic [5:0]  targetIn = '0;
  logic [3:0]  pageIn = '0;
  logic [12:0] fetchAddr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pc_stack u0 (
    .clk      (clk),
    .rstN     (rstN),
    .opIn     (opIn),
    .targetIn (targetIn),
    .pageIn   (pageIn),
    .fetchAddr(fetchAddr)
  );

  function automatic logic [12:0] mkAddr(int bank, int page, int offs);
    return 13'(bank * 1024 + page * 64 + offs);
  endfunction

  task automatic expectAddr(string req, logic [12:0] exp);
    checks++;
    if (fetchAddr !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, fetchAddr, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge act, look 1 unit later.
  task automatic doOp(logic [2:0] op, logic [5:0] tgt = '0, logic [3:0] pg = '0);
    @(negedge clk);
    opIn = op; targetIn = tgt; pageIn = pg;
    @(posedge clk);
    #1;
    opIn = OP_HOLD;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; opIn = OP_HOLD;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doOp(OP_STEP);
    applyReset();
    expectAddr("R1 reset address", 13'd0);
  endtask

  task automatic testSequential();
    applyReset();
    repeat (3) doOp(OP_STEP);
    expectAddr("R2 three steps", 13'd3);
    repeat (2) doOp(OP_HOLD);
    expectAddr("R3 hold", 13'd3);
    doOp(OP_SKIP);
    expectAddr("R10 skip", 13'd5);
  endtask

  task automatic testJump();
    applyReset();
    repeat (5) doOp(OP_STEP);
    doOp(OP_JUMP, 6'h2A);
    expectAddr("R4 jump in page 0", mkAddr(0, 0, 42));
    doOp(OP_PREF, '0, 4'd2);
    expectAddr("R8 prefix steps", mkAddr(0, 0, 43));
    doOp(OP_JUMP, 6'h11);
    expectAddr("R8 jump uses prefix page", mkAddr(0, 2, 17));
    doOp(OP_JUMP, 6'h05);
    expectAddr("R4 jump stays in page 2", mkAddr(0, 2, 5));
    doOp(OP_STEP);
    doOp(OP_CALL, 6'h03);
    expectAddr("R9 prefix consumed, call to page 15", mkAddr(0, 15, 3));
  endtask

  task automatic testPrefixKept();
    applyReset();
    doOp(OP_PREF, '0, 4'd9);
    doOp(OP_STEP);
    doOp(OP_HOLD);
    doOp(OP_SKIP);
    expectAddr("R9 address before call", 13'd4);
    doOp(OP_CALL, 6'h07);
    expectAddr("R9 prefix kept across step/skip", mkAddr(0, 9, 7));
    doOp(OP_RET);
    expectAddr("R6 return after prefixed call", 13'd5);
  endtask

  task automatic testCallReturn();
    applyReset();
    repeat (4) doOp(OP_STEP);
    doOp(OP_CALL, 6'h10);
    expectAddr("R5 call to page 15", mkAddr(0, 15, 16));
    doOp(OP_STEP);
    doOp(OP_CALL, 6'h20);
    expectAddr("R5 nested call", mkAddr(0, 15, 32));
    doOp(OP_RET);
    expectAddr("R6 inner return", mkAddr(0, 15, 18));
    doOp(OP_RET);
    expectAddr("R6 outer return", 13'd5);
    applyReset();
    doOp(OP_CALL, 6'h01);
    doOp(OP_RSKP);
    expectAddr("R7 return and skip", 13'd2);
  endtask

  task automatic testWrap();
    applyReset();
    for (int i = 1; i <= 4; i++) doOp(OP_CALL, 6'(i));
    expectAddr("R11 fourth call", mkAddr(0, 15, 4));
    doOp(OP_RET);
    expectAddr("R11 first return", mkAddr(0, 15, 4));
    doOp(OP_RET);
    doOp(OP_RET);
    expectAddr("R11 third return", mkAddr(0, 15, 2));
    doOp(OP_RET);
    expectAddr("R11 base slot overwritten", mkAddr(0, 15, 4));
  endtask

  task automatic testTopOfSpace();
    applyReset();
    for (int i = 0; i < 8191; i++) doOp(OP_STEP);
    expectAddr("R2 top of address space", 13'd8191);
    doOp(OP_CALL, 6'h05);
    expectAddr("R5 call keeps bank 7", mkAddr(7, 15, 5));
    doOp(OP_RET);
    expectAddr("R2 return address wraps to 0", 13'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    applyReset();
    testReset();
    testSequential();
    testJump();
    testPrefixKept();
    testCallReturn();
    testWrap();
    testTopOfSpace();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule